// File: doc/BRIEF.md
# Write-Protected Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It gives access to two 8-bit registers: a control register and a fault register. A transfer opens with an address byte. That byte names the device, picks one of the two registers and gives the direction. A fixed word-address byte follows it. Reads return the chosen register, most significant bit first. Writes carry a single data byte.

A write is applied only when three conditions all hold:

- the stop condition arrives right after a complete, acknowledged data byte;
- the write-protect pin is low;
- the write-enable latch is set.

Two reserved data codes written to the control register set or clear that latch. These two codes work even while the latch is clear.

Both bus lines are resynchronised to the system clock. SDA is driven only through an open-drain enable.

The control state machine has these states:

- **IDLE:** waits for a start condition.
- **ADDR:** shifts in the address byte. On the ninth falling edge it goes to **ADDR_ACK** on a match, or to **IGNORE** on a mismatch.
- **ADDR_ACK:** leads to **READ** for a read, or to **WORD** for a write.
- **WORD:** takes the word address. It goes to **WORD_ACK** if the byte is 0xFF, and to **IGNORE** otherwise.
- **WORD_ACK:** leads to **DATA**.
- **DATA:** takes the data byte, then goes to **DATA_ACK**.
- **DATA_ACK:** leads to **WAIT_STOP**.
- **WAIT_STOP:** on the next SCL rise, goes to **STOP_HOLD**.
- **STOP_HOLD:** a stop here commits the write. An SCL fall here means an extra bit was clocked, so it goes to **IGNORE**.
- **READ:** shifts out eight bits, then goes to **READ_ACK**.
- **READ_ACK:** a master ACK returns to **READ**. A master NACK goes to **IGNORE**.

A start condition in any state goes to **ADDR**. A stop condition in any state goes to **IDLE**.

Top module: `wp_serial_regslave`

## Requirements
- R1: After reset the write-enable latch, both registers and `sda_oe` are 0.
- R2: An address byte whose bits [7:4] differ from 1011, or whose bit 3 differs from `dev_sel`, or whose bit 2 is 1, gets no ACK, and the transfer changes nothing.
- R3: A matching address byte is acknowledged: `sda_oe` is 1 while SCL is high on the ninth clock. `sda_oe` only rises while SCL is low.
- R4: The word address must be 0xFF. Any other value gets no ACK, and the write is discarded.
- R5: Address bit 1 selects the register (1 = control, 0 = fault). Address bit 0 gives the direction (1 = read, 0 = write).
- R6: Writing 0x02 to the control register sets the latch, and writing 0x04 clears it, even while the latch is 0. These codes do not change the control register.
- R7: Any other register write takes effect only while the latch is 1.
- R8: While `wp_in` is 1, no register or latch changes.
- R9: A write is committed only by a stop that directly follows the acknowledged data byte. A stop inside a byte, or extra clocks after the data byte, discards it. An extra byte is not acknowledged.
- R10: A read drives the selected register MSB first. SDA changes while SCL is low. After a master ACK the same register is sent again. After a master NACK, SDA is released.
- R11: A repeated start restarts the address phase and releases SDA. Register state never changes except in the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wp_in | input | 1 | Write protect, high blocks every write |
| dev_sel | input | 1 | Strap value compared with address bit 3 |
| ctrl_q | output | 8 | Control register |
| fault_q | output | 8 | Fault register |
| wel_q | output | 1 | Write-enable latch |

## Verification
Some properties are checked on every cycle:

- register and latch stability while write protect is high;
- register stability while the latch is clear;
- no state change outside the cycle after a stop;
- SDA released after a start;
- the SDA enable rising only while SCL is low.

Other behaviour can only be shown by the bench's bus transactions:

- address decoding against the strap;
- word-address rejection;
- the latch codes;
- discarding of truncated or over-long writes;
- read data order;
- repeated starts.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
    localparam int DW = 8;
    localparam logic [3:0]    DEV_TYPE  = 4'b1011;
    localparam logic [DW-1:0] WORD_ADDR = 8'hFF;
    localparam logic [DW-1:0] WEL_SET   = 8'h02;
    localparam logic [DW-1:0] WEL_CLR   = 8'h04;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WORD, S_WORD_ACK, S_DATA,
        S_DATA_ACK, S_WAIT_STOP, S_STOP_HOLD, S_READ, S_READ_ACK, S_IGNORE
    } slv_state_t;
endpackage

// File: rtl/srs_bus_sync.sv
module srs_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edges while SCL stays high mark bus conditions
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/srs_reg_bank.sv
module srs_reg_bank
    import serial_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          sel_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          wp,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] fault_q,
    output logic          wel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            fault_q <= '0;
            wel_q   <= 1'b0;
        end else if (commit && !wp) begin
            if (sel_ctrl) begin
                if (wdata == WEL_SET)      wel_q  <= 1'b1;
                else if (wdata == WEL_CLR) wel_q  <= 1'b0;
                else if (wel_q)            ctrl_q <= wdata;
            end else if (wel_q) begin
                fault_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/wp_serial_regslave.sv
module wp_serial_regslave
    import serial_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic          wp_in,
    input  logic          dev_sel,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] fault_q,
    output logic          wel_q
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    slv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shreg_q, tx_q, wdata_q, rd_val;
    logic sel_q, rw_q, mack_q, oe_q, addr_hit, commit;

    srs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    assign addr_hit = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3] == dev_sel)
                      && !shreg_q[2];
    assign rd_val   = sel_q ? ctrl_q : fault_q;
    assign commit   = stop_evt && (state_q == S_STOP_HOLD);

    srs_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .sel_ctrl(sel_q),
        .wdata(wdata_q), .wp(wp_in), .ctrl_q(ctrl_q), .fault_q(fault_q),
        .wel_q(wel_q)
    );

    always_comb begin
        state_d = state_q;
        if (start_evt)      state_d = S_ADDR;
        else if (stop_evt)  state_d = S_IDLE;
        else begin
            unique case (state_q)
                S_IDLE:      ;
                S_ADDR:      if (scl_fall && cnt_q == LAST)
                                 state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK:  if (scl_fall) state_d = rw_q ? S_READ : S_WORD;
                S_WORD:      if (scl_fall && cnt_q == LAST)
                                 state_d = (shreg_q == WORD_ADDR) ? S_WORD_ACK : S_IGNORE;
                S_WORD_ACK:  if (scl_fall) state_d = S_DATA;
                S_DATA:      if (scl_fall && cnt_q == LAST) state_d = S_DATA_ACK;
                S_DATA_ACK:  if (scl_fall) state_d = S_WAIT_STOP;
                S_WAIT_STOP: if (scl_rise) state_d = S_STOP_HOLD;
                S_STOP_HOLD: if (scl_fall) state_d = S_IGNORE;
                S_READ:      if (scl_fall && cnt_q == LAST) state_d = S_READ_ACK;
                S_READ_ACK:  if (scl_fall) state_d = mack_q ? S_READ : S_IGNORE;
                S_IGNORE:    ;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            wdata_q <= '0;
            sel_q   <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (start_evt) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (stop_evt) begin
            oe_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_ADDR, S_WORD, S_DATA: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[DW-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST) begin
                        cnt_q <= '0;
                        if (state_q == S_ADDR) begin
                            oe_q  <= addr_hit;
                            sel_q <= shreg_q[1];
                            rw_q  <= shreg_q[0];
                        end else if (state_q == S_WORD) begin
                            oe_q <= (shreg_q == WORD_ADDR);
                        end else begin
                            oe_q    <= 1'b1;
                            wdata_q <= shreg_q;
                        end
                    end
                end
                S_ADDR_ACK, S_READ_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        if ((state_q == S_ADDR_ACK && rw_q) ||
                            (state_q == S_READ_ACK && mack_q)) begin
                            oe_q  <= ~rd_val[DW-1];
                            tx_q  <= {rd_val[DW-2:0], 1'b0};
                            cnt_q <= CW'(1);
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                S_WORD_ACK, S_DATA_ACK: if (scl_fall) oe_q <= 1'b0;
                S_READ: begin
                    if (scl_fall) begin
                        if (cnt_q == LAST) begin
                            oe_q <= 1'b0;
                        end else begin
                            oe_q  <= ~tx_q[DW-1];
                            tx_q  <= {tx_q[DW-2:0], 1'b0};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/wp_regslave_checker.sv
module wp_regslave_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_in,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       wel_q,
    input logic [7:0] ctrl_q,
    input logic [7:0] fault_q
);
    a_r8_wp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        wp_in |=> ($stable(ctrl_q) && $stable(fault_q) && $stable(wel_q)));

    a_r7_latch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_q |=> ($stable(ctrl_q) && $stable(fault_q)));

    a_r11_change_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_evt |=> ($stable(ctrl_q) && $stable(fault_q) && $stable(wel_q)));

    a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

    a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind wp_serial_regslave wp_regslave_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .sda_oe(sda_oe),
    .scl_s(scl_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .wel_q(wel_q), .ctrl_q(ctrl_q), .fault_q(fault_q)
);

// File: tb/wp_serial_regslave_test.sv
module wp_serial_regslave_test;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, m_sda = 1'b1, wp = 1'b0, dsel = 1'b0;
    logic sda_oe, wel_q, sda_line;
    logic [7:0] ctrl_q, fault_q;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    wp_serial_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .wp_in(wp), .dev_sel(dsel),
        .ctrl_q(ctrl_q), .fault_q(fault_q), .wel_q(wel_q)
    );

    typedef struct packed {
        logic [7:0] a, w, d;
        logic       wp, aack, wack;
        logic [7:0] ec, ef;
        logic       ew;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{8'hB2, 8'hFF, 8'h55, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R7 latch clear
        '{8'hB0, 8'hFF, 8'h33, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R7
        '{8'hB2, 8'hFF, 8'h02, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R8 code blocked
        '{8'hB2, 8'hFF, 8'h02, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1}, // R6 set
        '{8'hB2, 8'hFF, 8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h00, 1'b1}, // R5 ctrl
        '{8'hB0, 8'hFF, 8'h3C, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b1}, // R5 fault
        '{8'hB0, 8'hFF, 8'h77, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b1}, // R8
        '{8'hB2, 8'hFE, 8'h11, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b1}, // R4
        '{8'h32, 8'hFF, 8'h11, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1}, // R2 type
        '{8'hBA, 8'hFF, 8'h11, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1}, // R2 strap
        '{8'hB6, 8'hFF, 8'h11, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1}, // R2 bit2
        '{8'hB2, 8'hFF, 8'h04, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0}, // R6 clear
        '{8'hB2, 8'hFF, 8'h99, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0}  // R7
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; hw(); scl = 1'b1; hw(); ack = ~sda_line; scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(); scl = 1'b1; hw(); b = {b[6:0], sda_line}; scl = 1'b0;
        end
        m_sda = ~mack; hw(); scl = 1'b1; hw(); scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic write_txn(input logic [7:0] a, w, d, output logic aa, wa);
        logic da;
        bus_start();
        send_byte(a, aa);
        send_byte(w, wa);
        send_byte(d, da);
        bus_stop();
        hw();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic aa, wa, ack;
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hw();
        chk("R1 ctrl", ctrl_q, 8'h00);
        chk("R1 fault", fault_q, 8'h00);
        chk("R1 wel", {7'd0, wel_q}, 8'h00);
        chk("R1 oe", {7'd0, sda_oe}, 8'h00);

        for (int v = 0; v < 13; v++) begin
            wp = VECS[v].wp;
            write_txn(VECS[v].a, VECS[v].w, VECS[v].d, aa, wa);
            wp = 1'b0;
            chk("R3 addr ack", {7'd0, aa}, {7'd0, VECS[v].aack});
            chk("R4 word ack", {7'd0, wa}, {7'd0, VECS[v].wack});
            chk("R7 ctrl", ctrl_q, VECS[v].ec);
            chk("R5 fault", fault_q, VECS[v].ef);
            chk("R6 wel", {7'd0, wel_q}, {7'd0, VECS[v].ew});
        end

        // R10 direct read of control, twice via master ACK, then NACK
        bus_start();
        send_byte(8'hB3, ack);
        chk("R10 read addr ack", {7'd0, ack}, 8'h01);
        recv_byte(1'b1, rb);
        chk("R10 ctrl byte1", rb, 8'hA5);
        recv_byte(1'b0, rb);
        chk("R10 ctrl byte2", rb, 8'hA5);
        hw();
        chk("R10 released", {7'd0, sda_oe}, 8'h00);
        bus_stop();

        // R11 repeated start read of fault register
        bus_start();
        send_byte(8'hB0, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(8'hB1, ack);
        chk("R11 restart ack", {7'd0, ack}, 8'h01);
        recv_byte(1'b0, rb);
        chk("R11 fault read", rb, 8'h3C);
        bus_stop();
        hw();
        chk("R11 fault kept", fault_q, 8'h3C);

        // R9 truncated write with latch set
        write_txn(8'hB2, 8'hFF, 8'h02, aa, wa);
        chk("R6 set again", {7'd0, wel_q}, 8'h01);
        bus_start();
        send_byte(8'hB2, ack);
        send_byte(8'hFF, ack);
        send_bits(8'h10, 4);
        bus_stop();
        hw();
        chk("R9 truncated", ctrl_q, 8'hA5);

        // R9 extra byte
        bus_start();
        send_byte(8'hB2, ack);
        send_byte(8'hFF, ack);
        send_byte(8'h10, ack);
        send_byte(8'h20, ack);
        chk("R9 extra nack", {7'd0, ack}, 8'h00);
        bus_stop();
        hw();
        chk("R9 extra discarded", ctrl_q, 8'hA5);

        write_txn(8'hB2, 8'hFF, 8'h10, aa, wa);
        chk("R7 ctrl write", ctrl_q, 8'h10);

        // R1 reset in mid operation
        rst_n = 1'b0; hw(); rst_n = 1'b1; hw();
        chk("R1 ctrl again", ctrl_q, 8'h00);
        chk("R1 wel again", {7'd0, wel_q}, 8'h00);

        // R2 strap set to 1
        dsel = 1'b1;
        write_txn(8'hBA, 8'hFF, 8'h02, aa, wa);
        chk("R2 strap ack", {7'd0, aa}, 8'h01);
        chk("R2 strap wel", {7'd0, wel_q}, 8'h01);
        write_txn(8'hB2, 8'hFF, 8'h04, aa, wa);
        chk("R2 strap nack", {7'd0, aa}, 8'h00);
        chk("R2 wel kept", {7'd0, wel_q}, 8'h01);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule